// File: doc/BRIEF.md
# Hill-Climbing Power Tracking Sequencer

This block is a digital controller that steers the switching frequency of a charge pump fed by an energy harvester. Its goal is the largest average output current. It does this by repeatedly nudging an unsigned frequency control code one step at a time. A frequency generator outside the block turns that code into a pump clock. Current sensing and smoothing also happen outside the block, which receives each result as a digitised current sample.

Time is divided into sample periods. Each period runs three phases:

- **Working:** the sensor is powered down, so all of the pump current reaches the load.
- **Sensing:** the sensor is powered and the block takes exactly one current sample over a valid/ready stream. The sample is compared with the one kept from the previous period.
- **Evaluation:** the block decides the climb direction and steps the code.

The new direction is the XNOR of two bits: "the new sample is larger" and the previous direction. So the block keeps going while the current rises and turns round when it falls. Over time the code oscillates around the current peak.

The sample input follows valid/ready rules:
- `smp_ready` is raised only in the sensing phase, and only until one transfer has happened in the period.
- A transfer takes place on a clock edge where `smp_valid` and `smp_ready` are both high.
- When the source holds `smp_valid` low, the sensing phase stretches (back-pressure on the schedule) until a sample arrives.
- `smp_valid` outside that window is ignored.

The three phase lengths are cycle counts given on plain control inputs.

Top module: `hc_track_seq`

## Requirements
- R1: While reset is held and right after it, `freq_code` equals mid-scale (2^(CODE_W-1)), `climb_up` is 1, the block is in the working phase, and both `sense_en` and `smp_ready` are 0.
- R2: The phases run in the order working, sensing, evaluation, then working again. Working lasts `norm_len` cycles and evaluation lasts `eval_len` cycles. A programmed length of 0 behaves as 1, so the gap between two sensing phases is max(eval_len,1)+max(norm_len,1) cycles.
- R3: `sense_en` is 1 in every sensing cycle and 0 in every working and evaluation cycle.
- R4: `smp_ready` is 1 only in the sensing phase, and only before the period's single transfer. `smp_valid` asserted while `smp_ready` is 0 has no effect on any later output.
- R5: Sensing lasts max(sense_len,1) cycles when the transfer happens by then; otherwise it lasts until the cycle in which the transfer happens.
- R6: The first period after reset only records a baseline sample; `freq_code` and `climb_up` stay at their reset values through it.
- R7: In every later period the new direction is the XNOR of the compare bit and the old `climb_up`. The compare bit is 1 only when the new sample is strictly larger than the previous one, so an equal sample counts as 0.
- R8: The code steps once per period, at the end of the first evaluation cycle: +1 when the new direction is 1, −1 when it is 0. `freq_code` and `climb_up` hold their values in all other cycles.
- R9: `freq_code` saturates at 0 and at 2^CODE_W−1; it never wraps.
- R10: The previous sample used in the compare is always the one taken in the period just before. Two storage slots alternate their roles every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_len | input | PH_W | Working phase length in cycles (0 acts as 1) |
| sense_len | input | PH_W | Minimum sensing phase length in cycles (0 acts as 1) |
| eval_len | input | PH_W | Evaluation phase length in cycles (0 acts as 1) |
| smp_valid | input | 1 | Current sample offered |
| smp_data | input | SAMPLE_W | Digitised averaged current sample, unsigned |
| smp_ready | output | 1 | Block accepts a sample this cycle |
| sense_en | output | 1 | Sensor power enable, high during sensing |
| freq_code | output | CODE_W | Frequency control code, unsigned |
| climb_up | output | 1 | Current climb direction (1 = raise code) |

## Verification
The bench builds the block with CODE_W=4, SAMPLE_W=8 and PH_W=4. The narrow code brings both saturation rails within a couple of dozen periods, so the full climb to 15, the clamp there, the descent and the clamp at 0 are all driven. The short phase counters make it cheap to cover zero lengths and programmed lengths, and to delay samples past the end of the sensing window. Along the way the bench drives equal and falling samples through both direction states.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    PH_NORM  = 2'd0,
    PH_SENSE = 2'd1,
    PH_EVAL  = 2'd2
  } phase_e;
endpackage

// File: rtl/hc_phase_seq.sv
module hc_phase_seq
  import hc_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] norm_len,
  input  logic [PH_W-1:0] sense_len,
  input  logic [PH_W-1:0] eval_len,
  input  logic            got,
  input  logic            take,
  output phase_e          phase,
  output logic            eval_first
);
  localparam logic [PH_W-1:0] CNT_TOP = {PH_W{1'b1}};

  phase_e          ph_q, ph_d;
  logic [PH_W-1:0] cnt, lim;
  logic            adv;

  function automatic logic [PH_W-1:0] last_idx(input logic [PH_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_comb begin
    unique case (ph_q)
      PH_NORM:  lim = last_idx(norm_len);
      PH_SENSE: lim = last_idx(sense_len);
      default:  lim = last_idx(eval_len);
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_NORM:  ph_d = PH_SENSE;
      PH_SENSE: ph_d = PH_EVAL;
      default:  ph_d = PH_NORM;
    endcase
  end

  // sensing may only end once the period's sample is in
  assign adv = (cnt >= lim) && ((ph_q != PH_SENSE) || got || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_NORM;
      cnt  <= '0;
    end else if (adv) begin
      ph_q <= ph_d;
      cnt  <= '0;
    end else if (cnt != CNT_TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phase      = ph_q;
  assign eval_first = (ph_q == PH_EVAL) && (cnt == '0);

  a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |->
      ((ph_q == PH_SENSE && $past(ph_q) == PH_NORM) ||
       (ph_q == PH_EVAL  && $past(ph_q) == PH_SENSE) ||
       (ph_q == PH_NORM  && $past(ph_q) == PH_EVAL)));

  a_r5_sense_holds_for_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_SENSE && ph_q == PH_EVAL) |-> $past(got || take));
endmodule

// File: rtl/hc_sample_store.sv
module hc_sample_store #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] data,
  input  logic                swap,
  output logic                larger,
  output logic                got
);
  localparam int NSLOT = 2;

  logic [SAMPLE_W-1:0] slot [NSLOT];
  logic                sel;
  logic [SAMPLE_W-1:0] prev;

  // the slot not being written holds the previous period's sample
  assign prev = slot[~sel];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (take && (sel == 1'(g)))
        slot[g] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= 1'b0;
      got    <= 1'b0;
      larger <= 1'b0;
    end else begin
      if (take) begin
        larger <= (data > prev);
        got    <= 1'b1;
      end
      if (swap) begin
        sel <= ~sel;
        got <= 1'b0;
      end
    end
  end

  a_r4_one_take_per_period: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !got);

  a_r10_swap_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !got);
endmodule

// File: rtl/hc_step_ctl.sv
module hc_step_ctl #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              larger,
  output logic [CODE_W-1:0] code,
  output logic              dir
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic base;
  logic nd;

  assign nd = ~(larger ^ dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= CODE_MID;
      dir  <= 1'b1;
      base <= 1'b0;
    end else if (upd) begin
      base <= 1'b1;
      if (base) begin
        dir <= nd;
        if (nd) begin
          if (code != CODE_MAX) code <= code + 1'b1;
        end else begin
          if (code != '0) code <= code - 1'b1;
        end
      end
    end
  end

  a_r8_quiet_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(code) && $stable(dir)));

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (code == $past(code)) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(code) == CODE_MAX && code == '0) || ($past(code) == '0 && code == CODE_MAX)));

  a_r6_baseline_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !base) |=> (code == CODE_MID && dir));
endmodule

// File: rtl/hc_track_seq.sv
module hc_track_seq
  import hc_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SAMPLE_W = 10,
  parameter int PH_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PH_W-1:0]     norm_len,
  input  logic [PH_W-1:0]     sense_len,
  input  logic [PH_W-1:0]     eval_len,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_ready,
  output logic                sense_en,
  output logic [CODE_W-1:0]   freq_code,
  output logic                climb_up
);
  phase_e phase;
  logic   eval_first, got, take, larger;

  assign sense_en  = (phase == PH_SENSE);
  assign smp_ready = sense_en && !got;
  assign take      = smp_valid && smp_ready;

  hc_phase_seq #(.PH_W(PH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .norm_len   (norm_len),
    .sense_len  (sense_len),
    .eval_len   (eval_len),
    .got        (got),
    .take       (take),
    .phase      (phase),
    .eval_first (eval_first)
  );

  hc_sample_store #(.SAMPLE_W(SAMPLE_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .data   (smp_data),
    .swap   (eval_first),
    .larger (larger),
    .got    (got)
  );

  hc_step_ctl #(.CODE_W(CODE_W)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (eval_first),
    .larger (larger),
    .code   (freq_code),
    .dir    (climb_up)
  );

  a_r3_ready_needs_sensor: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> sense_en);

  a_r3_sensor_off_in_eval: assert property (@(posedge clk) disable iff (!rst_n)
    eval_first |-> !sense_en);
endmodule

// File: tb/hc_track_seq_bench.sv
module hc_track_seq_bench;
  localparam int CW = 4;
  localparam int SW = 8;
  localparam int PW = 4;
  localparam int CMAX = (1 << CW) - 1;

  typedef struct {
    int code;
    int dir;
    int hi;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] norm_len = 4'd3, sense_len = 4'd2, eval_len = 4'd2;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic          smp_ready, sense_en, climb_up;
  logic [CW-1:0] freq_code;

  int checks = 0, errors = 0;
  exp_t q[$];
  int m_code = 1 << (CW - 1), m_dir = 1, m_base = 0, m_prev = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hc_track_seq #(.CODE_W(CW), .SAMPLE_W(SW), .PH_W(PW)) u_hc_track_seq (
    .clk(clk), .rst_n(rst_n), .norm_len(norm_len), .sense_len(sense_len),
    .eval_len(eval_len), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .sense_en(sense_en), .freq_code(freq_code),
    .climb_up(climb_up)
  );

  function automatic int eff(input logic [PW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // driver: one period's sample, delayed d cycles into sensing
  task automatic send(input int s, input int d);
    exp_t e;
    int   cmp;
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    repeat (d) @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = SW'(s);
    if (m_base == 0) begin
      m_base = 1;
    end else begin
      cmp   = (s > m_prev) ? 1 : 0;
      m_dir = (cmp == m_dir) ? 1 : 0;
      if (m_dir == 1) m_code = (m_code == CMAX) ? CMAX : m_code + 1;
      else            m_code = (m_code == 0) ? 0 : m_code - 1;
    end
    m_prev = s;
    e.code = m_code;
    e.dir  = m_dir;
    e.hi   = (eff(sense_len) > d + 1) ? eff(sense_len) : d + 1;
    q.push_back(e);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // stray valid during the quiet gap must be refused (R4)
  task automatic stray();
    int gap;
    while (sense_en) @(negedge clk);
    gap = eff(eval_len) + eff(norm_len);
    for (int i = 1; i < gap; i++) begin
      smp_valid = 1'b1;
      smp_data  = 8'd0;
      chk("R4 ready low outside sensing", int'(smp_ready), 0);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  // monitor: scoreboard pop on each end of sensing
  initial begin
    int   hi = 0, lo = 0;
    bit   pend = 0, seen = 0;
    exp_t cur;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (sense_en) begin
        if (seen && lo > 0)
          chk("R2 gap between sensing phases", lo, eff(eval_len) + eff(norm_len));
        lo = 0;
        hi++;
      end else begin
        if (pend) begin
          chk("R7 R8 R9 R10 freq_code", int'(freq_code), cur.code);
          chk("R6 R7 R10 climb_up", int'(climb_up), cur.dir);
          pend = 0;
        end
        if (hi > 0) begin
          if (q.size() == 0) begin
            chk("R3 unexpected sensing phase", 1, 0);
          end else begin
            cur = q.pop_front();
            chk("R3 R5 sensing length", hi, cur.hi);
            pend = 1;
          end
          seen = 1;
          hi   = 0;
        end
        if (seen) lo++;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", int'(freq_code), 1 << (CW - 1));
    chk("R1 dir in reset", int'(climb_up), 1);
    chk("R1 sense_en in reset", int'(sense_en), 0);
    chk("R1 ready in reset", int'(smp_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 working phase after reset", int'(sense_en), 0);
    chk("R1 code after reset", int'(freq_code), 1 << (CW - 1));

    send(10, 0);           // R6 baseline
    send(20, 0);           // rising, up
    stray();
    send(30, 1);
    send(25, 0);           // falling, turn round
    send(20, 4);           // late sample stretches sensing (R5)
    send(20, 0);           // equal counts as not larger
    s = 30;
    for (int i = 0; i < 12; i++) begin   // keep descending to rail 0
      s += 5;
      send(s, i % 3);
    end
    norm_len = 4'd0; sense_len = 4'd0; eval_len = 4'd0;  // zero acts as one
    send(s - 10, 0);       // falling while going down: turn up
    s -= 10;
    stray();
    for (int i = 0; i < 10; i++) begin
      s += 5;
      send(s, 0);
    end
    norm_len = 4'd5; sense_len = 4'd3; eval_len = 4'd3;
    for (int i = 0; i < 10; i++) begin   // climb to rail max
      s += 5;
      send(s, (i == 4) ? 6 : 0);
    end
    repeat (30) @(negedge clk);
    chk("R8 scoreboard drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule